// File: doc/BRIEF.md
# Four-Channel Edge Event Counter

This block watches a set of asynchronous digital inputs and keeps an event count for each of them, readable by software over a simple register port. Each input is brought into the clock domain through a two-stage synchronizer, and its rising edges are then detected. Each channel has one configuration word. When that word is all ones, the channel is a plain edge counter. Any other value makes the channel a burst detector. The low half of the word gives a window length in one-second ticks, and the high half gives the number of edges needed. When enough edges arrive inside one window, the channel emits a one-cycle event pulse and adds one to its count.

The count is twice the register width and is read as two halves. A read of the low half captures the high half at the same moment, so a following read of the high half pairs with it. A write of any value to the low half clears the whole count. The high half ignores writes. A free-running prescaler makes the one-second tick from the system clock.

Top module: `pcnt_top`

## Requirements
- R1: After reset every configuration word reads all ones, every count reads zero, `event_o` is low and `rdata` is zero.
- R2: Address bits above bit 1 select the channel. The low two bits select the register: 0 is the configuration word (read/write), 1 is the count low half, 2 is the captured count high half, and 3 reads as zero. `rdata` is updated on the clock edge that samples `rd_en`.
- R3: With a configuration of all ones, each synchronized rising edge adds one to the count, and `event_o` for that channel stays low.
- R4: The count is 2*HALF_W bits wide. It carries from the low half into the high half and wraps from all ones to zero.
- R5: A write of any value to the count low half clears both halves on that edge. A clear takes precedence over an increment in the same cycle.
- R6: Writes to the count high half have no effect.
- R7: Reading the count low half captures the high half. A later high-half read returns that captured value, even if the count has moved since.
- R8: In the configuration word, bits [HALF_W/2-1:0] hold the window length in ticks and bits [HALF_W-1:HALF_W/2] hold the required edge count.
- R9: In burst mode, an edge with no window open opens one. When the required number of edges has been seen in the open window, `event_o` pulses for one cycle, the count increases by one, and the window closes.
- R10: An open window closes on the tick that uses up its length (a length of 0 closes on the first tick). The edges it gathered are discarded.
- R11: A required edge count of 0 or 1 makes every edge an event.
- R12: A write to the configuration word discards any partly filled window.
- R13: An input held high takes effect three clock edges after it is applied: two synchronizer stages and one edge-detect and update stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | NCH | Asynchronous channel inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address (channel, register select) |
| wdata | input | HALF_W | Write data |
| rdata | output | HALF_W | Registered read data |
| event_o | output | NCH | One-cycle burst event pulse per channel |

## Verification
Two situations are hard to reach from the ports: the wrap of the full count, and a high-half read that must differ from the live count. The bench makes the registers narrow (8-bit halves) and toggles one input every other cycle for 65535 edges. This brings the count to all ones, and one more edge wraps it to zero. For the capture check, the bench reads the low half at 0xFF, adds one edge, and only then reads the high half. Window expiry depends on the phase of the prescaler, which the bench cannot see. Edge spacings are therefore chosen well inside, or well beyond, every possible window bound.

// File: rtl/pcnt_pkg.sv
`timescale 1ns/1ps
// Package: shared register-select encoding for the edge event counter.
package pcnt_pkg;
    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pcnt_edge.sv
`timescale 1ns/1ps
// pcnt_edge: two-flop synchronizer followed by a rising-edge detector.
// Assumes din is asynchronous to clk. rise is high for one cycle, two
// edges after din goes high.
module pcnt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [2:0] shift_q;  // [0],[1] synchronizer, [2] previous sample

    // Shift the input through the synchronizer and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[1:0], din};
    end

    assign rise = shift_q[1] & ~shift_q[2];
endmodule

// File: rtl/pcnt_tick.sv
`timescale 1ns/1ps
// pcnt_tick: free-running prescaler that gives a one-cycle tick every
// CLKS_PER_TICK clocks. Assumes CLKS_PER_TICK >= 1.
module pcnt_tick #(
    parameter int CLKS_PER_TICK = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [W-1:0] LAST = W'(CLKS_PER_TICK - 1);

    logic [W-1:0] div_q;

    // Count clocks and wrap at the tick boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/pcnt_chan.sv
`timescale 1ns/1ps
// pcnt_chan: one counting channel. An all-ones cfg counts every edge.
// Otherwise cfg[FW-1:0] is the window length in ticks and cfg[HALF_W-1:FW]
// is the number of edges needed. An event bumps the count and pulses evt.
// Assumes rise and tick are single-cycle pulses. clr wins over an increment.
module pcnt_chan #(
    parameter int HALF_W = 16,
    localparam int CNT_W = 2 * HALF_W,
    localparam int FW    = HALF_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              tick,
    input  logic [HALF_W-1:0] cfg,
    input  logic              cfg_wr,
    input  logic              clr,
    output logic [CNT_W-1:0]  cnt,
    output logic              evt,
    output logic              up
);
    logic [FW-1:0] win_len, need;
    logic          active;
    logic [FW-1:0] edges, left;
    logic          expire, live, hit;
    logic [FW:0]   edges_nxt;

    assign up      = &cfg;
    assign win_len = cfg[FW-1:0];
    assign need    = cfg[HALF_W-1:FW];

    // Decide whether the open window ends now and whether this edge completes a burst.
    always_comb begin
        expire    = active & tick & (left <= FW'(1));
        live      = active & ~expire;
        edges_nxt = {1'b0, edges} + 1'b1;
        if (live) hit = rise & ~up & (edges_nxt >= {1'b0, need});
        else      hit = rise & ~up & (need <= FW'(1));
    end

    // Track the burst window: open, gather edges, time out or complete.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr || up || hit) begin
            active <= 1'b0;
            edges  <= '0;
            left   <= '0;
        end else if (rise) begin
            active <= 1'b1;
            if (live) begin
                edges <= edges + 1'b1;
                if (tick) left <= left - 1'b1;
            end else begin
                edges <= FW'(1);
                left  <= win_len;
            end
        end else if (expire) begin
            active <= 1'b0;
            edges  <= '0;
        end else if (active && tick) begin
            left <= left - 1'b1;
        end
    end

    // Maintain the event count and the registered event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            evt <= 1'b0;
        end else begin
            evt <= hit;
            if (clr)                   cnt <= '0;
            else if ((up & rise) | hit) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pcnt_top.sv
`timescale 1ns/1ps
// pcnt_top: NCH edge event counters behind a small register port.
// addr[AW-1:2] selects the channel and addr[1:0] the register (see pcnt_pkg).
// Reads are registered. A low-half read captures the high half.
// Assumes single-cycle wr_en/rd_en strobes from a synchronous master.
module pcnt_top
    import pcnt_pkg::*;
#(
    parameter int NCH           = 4,
    parameter int HALF_W        = 16,
    parameter int CLKS_PER_TICK = 200_000_000,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW    = CHW + 2,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    din,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata,
    output logic [NCH-1:0]    event_o
);
    logic                          tick;
    logic [CHW-1:0]                ch_idx;
    reg_sel_e                      sel;
    logic [NCH-1:0]                ch_hit;
    logic [NCH-1:0]                rise_w, up_w, clr_w, cfg_wr_w;
    logic [NCH-1:0][CNT_W-1:0]     cnt_w;
    logic [NCH-1:0][HALF_W-1:0]    cfg_q, hold_q;
    logic [HALF_W-1:0]             rd_mux;

    assign ch_idx = addr[AW-1:2];
    assign sel    = reg_sel_e'(addr[1:0]);

    pcnt_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_hit[g]   = (ch_idx == CHW'(g));
        assign clr_w[g]    = wr_en & ch_hit[g] & (sel == SEL_LO);
        assign cfg_wr_w[g] = wr_en & ch_hit[g] & (sel == SEL_CFG);

        pcnt_edge u_edge (
            .clk(clk), .rst_n(rst_n), .din(din[g]), .rise(rise_w[g])
        );

        pcnt_chan #(.HALF_W(HALF_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .rise(rise_w[g]), .tick(tick),
            .cfg(cfg_q[g]), .cfg_wr(cfg_wr_w[g]), .clr(clr_w[g]),
            .cnt(cnt_w[g]), .evt(event_o[g]), .up(up_w[g])
        );
    end

    // Hold configuration words and the captured high halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '1;
            hold_q <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (cfg_wr_w[i]) cfg_q[i] <= wdata;
                if (rd_en && ch_hit[i] && sel == SEL_LO)
                    hold_q[i] <= cnt_w[i][CNT_W-1:HALF_W];
            end
        end
    end

    // Select read data for the addressed channel and register.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_hit[i]) begin
                case (sel)
                    SEL_CFG: rd_mux = cfg_q[i];
                    SEL_LO:  rd_mux = cnt_w[i][HALF_W-1:0];
                    SEL_HI:  rd_mux = hold_q[i];
                    default: rd_mux = '0;
                endcase
            end
        end
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/pcnt_top_chk.sv
`timescale 1ns/1ps
// pcnt_top_chk: assertions on the per-channel counts and event pulses.
module pcnt_top_chk #(
    parameter int NCH   = 4,
    parameter int CNT_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NCH-1:0][CNT_W-1:0] cnt,
    input logic [NCH-1:0]           up,
    input logic [NCH-1:0]           clr,
    input logic [NCH-1:0]           event_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_a
        p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            clr[g] |=> (cnt[g] == '0));

        p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[g] != $past(cnt[g])) |->
                (cnt[g] == $past(cnt[g]) + 1'b1) || (cnt[g] == '0));

        p_evt_bump_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (event_o[g] && !$past(clr[g])) |-> (cnt[g] == $past(cnt[g]) + 1'b1));

        p_up_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (up[g] && $past(up[g])) |-> !event_o[g]);
    end
endmodule

bind pcnt_top pcnt_top_chk #(.NCH(NCH), .CNT_W(2 * HALF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .up(up_w), .clr(clr_w),
    .event_o(event_o)
);

// File: tb/pcnt_top_tb_top.sv
`timescale 1ns/1ps
module pcnt_top_tb_top;
    localparam int NCH = 4;
    localparam int HW  = 8;
    localparam int CPT = 16;

    typedef struct packed {
        logic [1:0]  ch;
        logic [7:0]  cfg;
        logic [15:0] nr;
        logic [7:0]  gap;
        logic [7:0]  exp_cnt;
        logic [7:0]  exp_ev;
    } vec_t;

    // ch, cfg, edges, gap, expected count, expected events
    localparam vec_t VECS [9] = '{
        '{2'd0, 8'hFF, 16'd5, 8'd2,   8'd5, 8'd0},  // R3 plain counting
        '{2'd1, 8'h32, 16'd6, 8'd2,   8'd2, 8'd2},  // R9 two bursts of 3
        '{2'd2, 8'h32, 16'd5, 8'd2,   8'd1, 8'd1},  // R9 partial second burst
        '{2'd3, 8'h12, 16'd4, 8'd2,   8'd4, 8'd4},  // R11 need 1
        '{2'd0, 8'h02, 16'd3, 8'd2,   8'd3, 8'd3},  // R11 need 0
        '{2'd1, 8'h32, 16'd2, 8'd100, 8'd0, 8'd0},  // R10 expiry between edges
        '{2'd2, 8'h22, 16'd4, 8'd3,   8'd2, 8'd2},  // R9 bursts of 2
        '{2'd3, 8'h21, 16'd2, 8'd40,  8'd0, 8'd0},  // R10 short window
        '{2'd0, 8'h2F, 16'd2, 8'd40,  8'd1, 8'd1}   // R8 R9 long window
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  din = '0;
    logic            wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]      addr = '0;
    logic [HW-1:0]   wdata = '0;
    logic [HW-1:0]   rdata;
    logic [NCH-1:0]  event_o;
    int              n_chk = 0, n_err = 0;
    int              ev_cnt [NCH];
    logic [HW-1:0]   rv;

    always #2.5 clk = ~clk;

    pcnt_top #(.NCH(NCH), .HALF_W(HW), .CLKS_PER_TICK(CPT)) dut_i (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .event_o(event_o)
    );

    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++)
            if (rst_n && event_o[c]) ev_cnt[c] = ev_cnt[c] + 1;
    end

    function automatic logic [3:0] ra(input int c, input int s);
        return {2'(c), 2'(s)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [HW-1:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [HW-1:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input int c, input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            din[c] = 1'b1;
            @(negedge clk);
            din[c] = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        for (int c = 0; c < NCH; c++) ev_cnt[c] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 event_o", 32'(event_o), 32'h0);
        check("R1 rdata", 32'(rdata), 32'h0);
        rd(ra(0, 0), rv); check("R1 cfg", 32'(rv), 32'hFF);
        rd(ra(0, 1), rv); check("R1 lo", 32'(rv), 32'h0);
        rd(ra(0, 2), rv); check("R1 hi", 32'(rv), 32'h0);

        // R2 map: unused select reads zero, config reads back
        rd(ra(1, 3), rv); check("R2 unused", 32'(rv), 32'h0);
        wr(ra(1, 0), 8'h5C);
        rd(ra(1, 0), rv); check("R2 cfg readback", 32'(rv), 32'h5C);

        // Vector walk: R3 R8 R9 R10 R11
        for (int i = 0; i < 9; i++) begin
            wr(ra(VECS[i].ch, 0), VECS[i].cfg);
            wr(ra(VECS[i].ch, 1), 8'hA5);
            ev_cnt[VECS[i].ch] = 0;
            pulse(VECS[i].ch, int'(VECS[i].nr), int'(VECS[i].gap));
            repeat (6) @(negedge clk);
            rd(ra(VECS[i].ch, 1), rv);
            check($sformatf("R3 R9 R10 R11 vec%0d count", i), 32'(rv), 32'(VECS[i].exp_cnt));
            check($sformatf("R3 R9 R10 R11 vec%0d events", i), 32'(ev_cnt[VECS[i].ch]), 32'(VECS[i].exp_ev));
        end

        // R13 latency: need 1, event appears on the third edge
        wr(ra(2, 0), 8'h12);
        din[2] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R13 early", 32'(event_o[2]), 32'h0);
        @(negedge clk);
        check("R13 on time", 32'(event_o[2]), 32'h1);
        din[2] = 1'b0;
        repeat (4) @(negedge clk);

        // R12 config write discards a partial window
        wr(ra(1, 0), 8'h32);
        wr(ra(1, 1), 8'h00);
        pulse(1, 2, 2);
        repeat (4) @(negedge clk);
        wr(ra(1, 0), 8'h32);
        pulse(1, 1, 2);
        repeat (6) @(negedge clk);
        rd(ra(1, 1), rv); check("R12 after rewrite", 32'(rv), 32'h0);
        pulse(1, 2, 2);
        repeat (6) @(negedge clk);
        rd(ra(1, 1), rv); check("R12 fresh burst", 32'(rv), 32'h1);

        // R7 capture and R4 carry on channel 0
        wr(ra(0, 0), 8'hFF);
        wr(ra(0, 1), 8'h11);
        pulse(0, 255, 1);
        repeat (6) @(negedge clk);
        rd(ra(0, 1), rv); check("R4 lo at 0xFF", 32'(rv), 32'hFF);
        pulse(0, 1, 1);
        repeat (6) @(negedge clk);
        rd(ra(0, 2), rv); check("R7 captured hi", 32'(rv), 32'h0);
        rd(ra(0, 1), rv); check("R4 lo after carry", 32'(rv), 32'h0);
        rd(ra(0, 2), rv); check("R4 R7 hi after carry", 32'(rv), 32'h1);

        // R6 high half ignores writes
        wr(ra(0, 2), 8'h77);
        rd(ra(0, 1), rv); check("R6 lo", 32'(rv), 32'h0);
        rd(ra(0, 2), rv); check("R6 hi", 32'(rv), 32'h1);

        // R5 any write to low half clears both halves
        wr(ra(0, 1), 8'h3C);
        rd(ra(0, 1), rv); check("R5 lo", 32'(rv), 32'h0);
        rd(ra(0, 2), rv); check("R5 hi", 32'(rv), 32'h0);

        // R4 wrap on channel 3
        wr(ra(3, 0), 8'hFF);
        wr(ra(3, 1), 8'h00);
        pulse(3, 65535, 1);
        repeat (6) @(negedge clk);
        rd(ra(3, 1), rv); check("R4 full lo", 32'(rv), 32'hFF);
        rd(ra(3, 2), rv); check("R4 full hi", 32'(rv), 32'hFF);
        pulse(3, 1, 1);
        repeat (6) @(negedge clk);
        rd(ra(3, 1), rv); check("R4 wrap lo", 32'(rv), 32'h0);
        rd(ra(3, 2), rv); check("R4 wrap hi", 32'(rv), 32'h0);

        summary();
    end
endmodule